// File: doc/BRIEF.md
# Shadow Register Set File

This block is the general-purpose register storage for a 32-bit core. It holds several full copies of the 32-entry register set, and one of them is current at any moment. Two combinational read ports and one clocked write port all address the current set. A write that lands in the current set is forwarded to a read of the same register in the same cycle.

When an interrupt is accepted, the block records the current set index as the previous index. It then makes current the set that a programmable table assigns to the request's priority level. The interrupted code's registers are left as they were. A return request makes the previous set current again. Two transfer operations let a handler reach the interrupted context. One pulls a register from the previous set into the current set. The other pushes a current-set register into the previous set. This lets a handler borrow the interrupted code's stack pointer and hand it back later.

The block also decides whether a request is accepted. It accepts the request only when the requested level is strictly higher than the core's current level.

Top module: `srf_top`

## Requirements
- R1: Register 0 reads as zero in every set. Writes to it have no effect.
- R2: Both read ports return the current set's register combinationally. A write takes effect at the rising clock edge. While a write to the current set is pending, a read of the same register returns the new data in that same cycle.
- R3: The sets are independent. A write to one set leaves every register of the other sets unchanged.
- R4: A request (`irq_req` high) is accepted, and `irq_taken` is driven high, only when `irq_level` > `cur_level`. An equal or lower level leaves the set indices unchanged.
- R5: On an accepted request, the previous index becomes the old current index. The current index becomes the table entry for `irq_level`. The contents of the interrupted set are unchanged.
- R6: `ret_req` copies the previous index into the current index. If an accepted request arrives in the same cycle, the accepted request wins and `ret_req` is ignored.
- R7: Read-previous (`pull_en`) writes register `pull_src` of the previous set into register `pull_dst` of the current set. If `wr_en` targets the current set in the same cycle, read-previous takes priority.
- R8: Write-previous (`push_en`) writes register `push_src` of the current set into register `push_dst` of the previous set. If the previous and current sets are the same and a current-set write occurs in the same cycle, the current-set write wins.
- R9: Writing `cfg_we` with a level and a set index programs the level-to-set table. After reset, every level maps to set 0. The entry for level 0 cannot be written.
- R10: Reset sets both the current and previous indices to 0 and clears every register.
- R11: A second accepted request before a return overwrites the previous index with the set that is current at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Current-set write enable |
| wr_addr | input | 5 | Write register number |
| wr_data | input | 32 | Write data |
| pull_en | input | 1 | Read-previous transfer enable |
| pull_src | input | 5 | Register in previous set to read |
| pull_dst | input | 5 | Register in current set to write |
| push_en | input | 1 | Write-previous transfer enable |
| push_src | input | 5 | Register in current set to read |
| push_dst | input | 5 | Register in previous set to write |
| irq_req | input | 1 | Interrupt request |
| irq_level | input | 3 | Requested priority level |
| cur_level | input | 3 | Core's current priority level |
| irq_taken | output | 1 | Request accepted this cycle |
| ret_req | input | 1 | Return: restore previous set |
| cfg_we | input | 1 | Table write enable |
| cfg_level | input | 3 | Table entry (level) to write |
| cfg_set | input | 2 | Set index for that level |
| cur_set | output | 2 | Current set index |
| prev_set | output | 2 | Previous set index |

## Verification
The hardest state to reach is a handler that has moved values across contexts and then come back to the interrupted set. Only there can the bench see that the pushed value arrived and the interrupted registers survived. The stimulus fills set 0, takes a request into set 2, pushes and pulls, and nests into set 3. It then returns and finally re-enters set 0 through a level that the table maps back to it, reading the registers there to confirm both effects.

// File: rtl/srf_pkg.sv
package srf_pkg;
    typedef enum logic [1:0] {
        WSRC_NONE,
        WSRC_PORT,
        WSRC_PULL,
        WSRC_PUSH
    } wsrc_e;
endpackage

// File: rtl/srf_bank.sv
module srf_bank #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int NRD  = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);
    logic [XLEN-1:0] regs_d [NREG];
    logic [XLEN-1:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (we && waddr != '0) regs_d[waddr] = wdata;
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs_q[raddr[p]];
    end
endmodule

// File: rtl/srf_map.sv
module srf_map #(
    parameter int NUM_SETS = 4,
    parameter int PRIO_W   = 3,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int LEVELS  = 1 << PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PRIO_W-1:0] cfg_level,
    input  logic [SET_W-1:0]  cfg_set,
    input  logic [PRIO_W-1:0] look_level,
    output logic [SET_W-1:0]  look_set
);
    logic [SET_W-1:0] tab_d [LEVELS];
    logic [SET_W-1:0] tab_q [LEVELS];

    always_comb begin
        for (int i = 0; i < LEVELS; i++) tab_d[i] = tab_q[i];
        if (cfg_we && cfg_level != '0) tab_d[cfg_level] = cfg_set;
        tab_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LEVELS; i++) tab_q[i] <= '0;
        end else begin
            for (int i = 0; i < LEVELS; i++) tab_q[i] <= tab_d[i];
        end
    end

    assign look_set = tab_q[look_level];

    // R9: level 0 always resolves to set 0
    a_r9_level0_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (look_level == '0) |-> (look_set == '0));
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl #(
    parameter int NUM_SETS = 4,
    parameter int PRIO_W   = 3,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_level,
    input  logic [PRIO_W-1:0] cur_level,
    input  logic              ret_req,
    input  logic [SET_W-1:0]  target_set,
    output logic              irq_taken,
    output logic [SET_W-1:0]  cur_set,
    output logic [SET_W-1:0]  prev_set
);
    typedef struct packed {
        logic [SET_W-1:0] cur;
        logic [SET_W-1:0] prev;
    } idx_t;

    idx_t st_d, st_q;
    logic take_d;

    always_comb begin
        st_d   = st_q;
        take_d = irq_req && (irq_level > cur_level);
        if (take_d) begin
            st_d.prev = st_q.cur;
            st_d.cur  = target_set;
        end else if (ret_req) begin
            st_d.cur  = st_q.prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_taken = take_d;
    assign cur_set   = st_q.cur;
    assign prev_set  = st_q.prev;

    // R4: a request at or below the current level never moves the indices
    a_r4_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_level <= cur_level && !ret_req) |=> ($stable(cur_set) && $stable(prev_set)));
    // R5: entry saves the interrupted index
    a_r5_entry_saves: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> (prev_set == $past(cur_set)));
    // R6: return restores the saved index and keeps it
    a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !irq_taken) |=> (cur_set == $past(prev_set) && $stable(prev_set)));
endmodule

// File: rtl/srf_top.sv
module srf_top #(
    parameter int XLEN     = 32,
    parameter int NREG     = 32,
    parameter int NUM_SETS = 4,
    parameter int PRIO_W   = 3,
    localparam int AW      = $clog2(NREG),
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [XLEN-1:0]   rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [XLEN-1:0]   rd_b_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              pull_en,
    input  logic [AW-1:0]     pull_src,
    input  logic [AW-1:0]     pull_dst,
    input  logic              push_en,
    input  logic [AW-1:0]     push_src,
    input  logic [AW-1:0]     push_dst,
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] irq_level,
    input  logic [PRIO_W-1:0] cur_level,
    output logic              irq_taken,
    input  logic              ret_req,
    input  logic              cfg_we,
    input  logic [PRIO_W-1:0] cfg_level,
    input  logic [SET_W-1:0]  cfg_set,
    output logic [SET_W-1:0]  cur_set,
    output logic [SET_W-1:0]  prev_set
);
    import srf_pkg::*;

    localparam int NRD    = 4;
    localparam int P_A    = 0;
    localparam int P_B    = 1;
    localparam int P_PUSH = 2;
    localparam int P_PULL = 3;

    logic [SET_W-1:0] target_set;
    logic [NRD-1:0][AW-1:0]   raddr;
    logic [NRD-1:0][XLEN-1:0] bank_rd [NUM_SETS];
    logic             bank_we    [NUM_SETS];
    logic [AW-1:0]    bank_waddr [NUM_SETS];
    logic [XLEN-1:0]  bank_wdata [NUM_SETS];
    wsrc_e            bank_src   [NUM_SETS];

    logic [XLEN-1:0]  prev_pull_val;
    logic [XLEN-1:0]  cur_push_val;
    logic [XLEN-1:0]  cur_a_raw, cur_b_raw;
    logic             cw_en;
    logic [AW-1:0]    cw_addr;
    logic [XLEN-1:0]  cw_data;

    srf_map #(.NUM_SETS(NUM_SETS), .PRIO_W(PRIO_W)) u_map (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_level(cfg_level), .cfg_set(cfg_set),
        .look_level(irq_level), .look_set(target_set)
    );

    srf_ctrl #(.NUM_SETS(NUM_SETS), .PRIO_W(PRIO_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .irq_req(irq_req), .irq_level(irq_level), .cur_level(cur_level),
        .ret_req(ret_req), .target_set(target_set),
        .irq_taken(irq_taken), .cur_set(cur_set), .prev_set(prev_set)
    );

    always_comb begin
        raddr         = '0;
        raddr[P_A]    = rd_a_addr;
        raddr[P_B]    = rd_b_addr;
        raddr[P_PUSH] = push_src;
        raddr[P_PULL] = pull_src;
    end

    assign prev_pull_val = bank_rd[prev_set][P_PULL];
    assign cur_push_val  = bank_rd[cur_set][P_PUSH];
    assign cur_a_raw     = bank_rd[cur_set][P_A];
    assign cur_b_raw     = bank_rd[cur_set][P_B];

    // write arbitration for the current set: pull beats the port write
    always_comb begin
        cw_en   = 1'b0;
        cw_addr = '0;
        cw_data = '0;
        if (pull_en) begin
            cw_en   = 1'b1;
            cw_addr = pull_dst;
            cw_data = prev_pull_val;
        end else if (wr_en) begin
            cw_en   = 1'b1;
            cw_addr = wr_addr;
            cw_data = wr_data;
        end
    end

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_comb begin
            bank_src[s] = WSRC_NONE;
            if (cur_set == SET_W'(s) && pull_en)       bank_src[s] = WSRC_PULL;
            else if (cur_set == SET_W'(s) && wr_en)    bank_src[s] = WSRC_PORT;
            else if (prev_set == SET_W'(s) && push_en) bank_src[s] = WSRC_PUSH;
            unique case (bank_src[s])
                WSRC_PULL: begin
                    bank_we[s] = 1'b1; bank_waddr[s] = pull_dst; bank_wdata[s] = prev_pull_val;
                end
                WSRC_PORT: begin
                    bank_we[s] = 1'b1; bank_waddr[s] = wr_addr;  bank_wdata[s] = wr_data;
                end
                WSRC_PUSH: begin
                    bank_we[s] = 1'b1; bank_waddr[s] = push_dst; bank_wdata[s] = cur_push_val;
                end
                default: begin
                    bank_we[s] = 1'b0; bank_waddr[s] = '0;       bank_wdata[s] = '0;
                end
            endcase
        end

        srf_bank #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .we(bank_we[s]), .waddr(bank_waddr[s]), .wdata(bank_wdata[s]),
            .raddr(raddr), .rdata(bank_rd[s])
        );
    end

    // same-cycle forwarding of a pending current-set write
    always_comb begin
        rd_a_data = cur_a_raw;
        rd_b_data = cur_b_raw;
        if (cw_en && cw_addr != '0 && cw_addr == rd_a_addr) rd_a_data = cw_data;
        if (cw_en && cw_addr != '0 && cw_addr == rd_b_addr) rd_b_data = cw_data;
    end

    // R1: register 0 reads zero on both ports
    a_r1_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0 && (rd_b_addr != '0 || rd_b_data == '0)));
    // R2: a port write with no pull is visible on port B in the same cycle
    a_r2_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pull_en && wr_addr != '0 && wr_addr == rd_b_addr) |-> (rd_b_data == wr_data));
    // R2: the written value is held after the edge when nothing else changes
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pull_en && !irq_taken && !ret_req && wr_addr != '0 && wr_addr == rd_a_addr)
        |=> ($stable(rd_a_addr) && $stable(cur_set)) |-> (rd_a_data == $past(wr_data)));
endmodule

// File: tb/sim_srf_top.sv
module sim_srf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, pull_en = 1'b0, push_en = 1'b0;
    logic [4:0]  pull_src = '0, pull_dst = '0, push_src = '0, push_dst = '0;
    logic        irq_req = 1'b0, ret_req = 1'b0, cfg_we = 1'b0, irq_taken;
    logic [2:0]  irq_level = '0, cur_level = '0, cfg_level = '0;
    logic [1:0]  cfg_set = '0, cur_set, prev_set;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    srf_top u0 (.*);

    // {register, value}; read-back expectation follows R1
    localparam logic [36:0] VEC [7] = '{
        {5'd1,  32'h1111_1111},
        {5'd5,  32'h5555_0000},
        {5'd0,  32'hDEAD_BEEF},
        {5'd31, 32'hFFFF_0001},
        {5'd2,  32'h0000_0002},
        {5'd5,  32'h5555_AAAA},
        {5'd17, 32'h8000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        rd_a_addr = a;
        rd_b_addr = a;
        #1;
        check(req, rd_a_data, exp);
        check(req, rd_b_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 cur", 32'(cur_set), 32'd0);
        check("R10 prev", 32'(prev_set), 32'd0);
        rd(5'd5, 32'h0, "R10 regs clear");

        // R1 / R2: vector walk in set 0
        foreach (VEC[i]) begin
            wr_en = 1'b1; wr_addr = VEC[i][36:32]; wr_data = VEC[i][31:0];
            tick();
            wr_en = 1'b0;
            rd(VEC[i][36:32], (VEC[i][36:32] == 5'd0) ? 32'h0 : VEC[i][31:0], "R1/R2 vector");
        end

        // R2: same-cycle forwarding
        rd_a_addr = 5'd7; rd_b_addr = 5'd7;
        wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h0000_0077;
        #1;
        check("R2 forward", rd_a_data, 32'h0000_0077);
        tick();
        wr_en = 1'b0;

        // R9: program the table (level 0 write must not take)
        cfg_we = 1'b1;
        cfg_level = 3'd4; cfg_set = 2'd2; tick();
        cfg_level = 3'd6; cfg_set = 2'd3; tick();
        cfg_level = 3'd0; cfg_set = 2'd1; tick();
        cfg_we = 1'b0;

        // R4: equal level is refused
        irq_req = 1'b1; irq_level = 3'd4; cur_level = 3'd4;
        #1;
        check("R4 equal refused", 32'(irq_taken), 32'd0);
        tick();
        check("R4 set kept", 32'(cur_set), 32'd0);

        // R4 / R5 / R9: higher level accepted, goes to set 2
        cur_level = 3'd3;
        #1;
        check("R4 higher taken", 32'(irq_taken), 32'd1);
        tick();
        irq_req = 1'b0;
        check("R5/R9 cur", 32'(cur_set), 32'd2);
        check("R5 prev", 32'(prev_set), 32'd0);

        // R3: new set is empty
        rd(5'd5, 32'h0, "R3 fresh set");
        wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'hAAAA_0005;
        tick();
        wr_en = 1'b0;

        // R8: push current r5 into previous r9
        push_en = 1'b1; push_src = 5'd5; push_dst = 5'd9;
        tick();
        push_en = 1'b0;

        // R7: pull previous r1 into current r10
        pull_en = 1'b1; pull_src = 5'd1; pull_dst = 5'd10;
        tick();
        pull_en = 1'b0;
        rd(5'd10, 32'h1111_1111, "R7 pull");

        // R7: pull beats port write to same register
        pull_en = 1'b1; pull_src = 5'd2; pull_dst = 5'd11;
        wr_en = 1'b1; wr_addr = 5'd11; wr_data = 32'h0000_0BAD;
        tick();
        pull_en = 1'b0; wr_en = 1'b0;
        rd(5'd11, 32'h0000_0002, "R7 priority");

        // R11: nested entry overwrites previous index
        irq_req = 1'b1; irq_level = 3'd6; cur_level = 3'd4;
        tick();
        irq_req = 1'b0;
        check("R11 cur", 32'(cur_set), 32'd3);
        check("R11 prev", 32'(prev_set), 32'd2);

        // R6: return restores
        ret_req = 1'b1;
        tick();
        check("R6 return", 32'(cur_set), 32'd2);
        tick();
        ret_req = 1'b0;
        check("R6 second return", 32'(cur_set), 32'd2);
        rd(5'd5, 32'hAAAA_0005, "R3 set 2 kept");

        // R6: entry wins over return; level 7 maps to set 0
        irq_req = 1'b1; irq_level = 3'd7; cur_level = 3'd0; ret_req = 1'b1;
        tick();
        irq_req = 1'b0; ret_req = 1'b0;
        check("R6 entry wins cur", 32'(cur_set), 32'd0);
        check("R6 entry wins prev", 32'(prev_set), 32'd2);

        // R8 / R5 / R3: interrupted set contents
        rd(5'd9, 32'hAAAA_0005, "R8 push landed");
        rd(5'd5, 32'h5555_AAAA, "R5 set 0 untouched");
        rd(5'd1, 32'h1111_1111, "R3 set 0 r1");
        rd(5'd0, 32'h0, "R1 zero");

        // R9: level 0 entry cannot be reprogrammed; a level-1 request still goes to set 0
        irq_req = 1'b1; irq_level = 3'd1; cur_level = 3'd0;
        tick();
        irq_req = 1'b0;
        check("R9 default map", 32'(cur_set), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule